// File: doc/BRIEF.md
# Buck Channel Gate Timing Sequencer

This block is the digital timing core of one channel of a synchronous buck controller. It decides, cycle by cycle, when the high-side switch and the low-side switch of the channel are commanded on. It runs in one of three modes. The first is fixed-frequency continuous conduction, paced by the channel's normal switching tick. The second is light-load pulse skipping, in which single fixed-length top pulses are fired on edges of a four-times-faster clock. The third is a short transient boost, in which the channel is re-triggered on every rising edge of that faster clock.

The analog parts of the channel enter as single-bit digital inputs, each one clock wide or held as a level:
- the PWM comparator's turn-off decision,
- a feedback-below-droop comparator,
- a negative inductor current (zero-cross) flag,
- a transient detector.

The edges of the fast clock and the normal switching tick arrive as one-cycle strobes in the system clock domain. All ports are plain control and status signals. There is no streamed data and no handshake. Dead times between the two gate commands are counted in system clock cycles.

Top module: `bk_gate_timing`

## Requirements
- R1: While `rst_n` is low, `top_gate_o`, `bot_gate_o` and `mode_o` are 0. `mode_o` encodes 0 = fixed frequency, 1 = skip, 2 = boost, and 3 never appears. After reset the low-side gate turns on exactly DT_TB cycles after the release.
- R2: In fixed-frequency mode, a `sw_tick_i` strobe in cycle c starts a top request in the next cycle. A `pwm_off_i` pulse in cycle c+L ends it. When the bottom gate was on before the request, the top gate is high for exactly L-DT_BT cycles.
- R3: Both gates are never high together. The top gate rises only after at least DT_BT cycles with both gates low. The bottom gate rises only after at least DT_TB such cycles.
- R4: Outside skip mode the bottom gate turns on after every top pulse and stays on while `zc_i` is high, so reverse inductor current is allowed.
- R5: While the forced-PWM pin `fpwm_n_i` is low, or while `ss_active_i` is high, the channel never enters skip mode.
- R6: Skip mode is entered at a `sw_tick_i` strobe when `zc_i` was seen high in each of the last RUN_LEN switching periods. With only RUN_LEN-1 such periods the channel stays in fixed-frequency mode.
- R7: In skip mode each top pulse lasts `on_len + floor(on_len/2)` cycles. Here `on_len` is the request length of the last fixed-frequency pulse, counted from the cycle after the tick up to and including the `pwm_off_i` cycle. `pwm_off_i` has no effect in skip mode.
- R8: In skip mode, a pulse starts only on a cycle carrying `hf_rise_i` or `hf_fall_i` while `fb_low_i` is high. The top gate rises two clocks after that strobe cycle. With `fb_low_i` high and no strobe, no pulse starts.
- R9: After a skip pulse ends, the first fast-clock edge strobe only re-arms the sequencer and cannot start a pulse. This gives a minimum off-time of half a fast-clock period.
- R10: In skip mode, a cycle with `zc_i` high turns the bottom gate off in the next cycle.
- R11: Skip mode is left at a `sw_tick_i` strobe after RUN_LEN consecutive switching periods with no `zc_i`, with no skip pulse active. At that same strobe a fixed-frequency top request starts. With RUN_LEN-1 such periods the channel stays in skip mode.
- R12: In fixed-frequency mode, `tre_i` moves the channel to boost mode in the next cycle. There, each of the next HF_PER_SW `hf_rise_i` strobes starts a top request, ended by `pwm_off_i`. The following rising strobe returns the channel to fixed-frequency mode. `tre_i` is ignored in skip mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_tick_i | input | 1 | One-cycle strobe at the start of each normal switching period |
| hf_rise_i | input | 1 | One-cycle strobe on each rising edge of the 4x clock |
| hf_fall_i | input | 1 | One-cycle strobe on each falling edge of the 4x clock |
| pwm_off_i | input | 1 | PWM comparator: ends the current top request |
| fb_low_i | input | 1 | Feedback is below the droop reference |
| zc_i | input | 1 | Inductor current is negative |
| tre_i | input | 1 | Load transient detected |
| fpwm_n_i | input | 1 | Forced-PWM pin, active low |
| ss_active_i | input | 1 | Soft-start in progress |
| top_gate_o | output | 1 | High-side gate command |
| bot_gate_o | output | 1 | Low-side gate command |
| mode_o | output | 2 | Current mode, encoded as in R1 |

## Verification
The bench attacks the RUN_LEN boundaries on both sides. It runs exactly RUN_LEN-1 qualifying periods before the entry into skip mode and before the exit from it. An off-by-one counter would switch mode one period early, and the bench would see that as a wrong `mode_o` or an unexpected top pulse.

Forced-PWM and soft-start are held through long runs of negative current. A design that ignored either would drop into skip mode and stop producing the expected fixed-frequency pulses.

In skip mode the bench checks three things:
- the 1.5x pulse length, while `pwm_off_i` is toggled mid-pulse;
- that a fire happens on either strobe edge;
- that the first edge after a pulse is consumed by re-arming.

A design with no minimum off-time would emit an extra pulse there. The boost run counts exactly HF_PER_SW short pulses before the channel returns to fixed-frequency mode.

// File: rtl/bk_gate_pkg.sv
package bk_gate_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED = 2'd0,
    MODE_SKIP  = 2'd1,
    MODE_BOOST = 2'd2
  } bk_mode_e;
endpackage

// File: rtl/bk_zc_runs.sv
// Counts consecutive switching periods with and without a zero-cross event.
module bk_zc_runs #(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic period_i,
  input  logic zc_i,
  output logic neg_done_o,
  output logic pos_done_o
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN);
  localparam logic [CW-1:0] RUN_TH  = CW'(RUN_LEN - 1);

  logic          seen_q;
  logic          per_zc;
  logic [CW-1:0] neg_run_q, pos_run_q;

  assign per_zc     = seen_q | zc_i;
  assign neg_done_o = per_zc & (neg_run_q >= RUN_TH);
  assign pos_done_o = ~per_zc & (pos_run_q >= RUN_TH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      neg_run_q <= '0;
      pos_run_q <= '0;
    end else if (period_i) begin
      seen_q <= 1'b0;
      if (per_zc) begin
        pos_run_q <= '0;
        if (neg_run_q != RUN_MAX) neg_run_q <= neg_run_q + 1'b1;
      end else begin
        neg_run_q <= '0;
        if (pos_run_q != RUN_MAX) pos_run_q <= pos_run_q + 1'b1;
      end
    end else begin
      seen_q <= per_zc;
    end
  end
endmodule

// File: rtl/bk_pulse_seq.sv
// Mode selection and top-request generation for one channel.
module bk_pulse_seq
  import bk_gate_pkg::*;
#(
  parameter int ON_W      = 10,
  parameter int HF_PER_SW = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     period_i,
  input  logic     hf_rise_i,
  input  logic     hf_fall_i,
  input  logic     pwm_off_i,
  input  logic     fb_low_i,
  input  logic     tre_i,
  input  logic     force_i,
  input  logic     neg_done_i,
  input  logic     pos_done_i,
  output logic     req_o,
  output bk_mode_e mode_o
);
  localparam int BW = $clog2(HF_PER_SW + 1);
  localparam logic [ON_W-1:0] ON_SAT = {{(ON_W-1){1'b1}}, 1'b0};

  bk_mode_e        mode_q;
  logic            req_q, armed_q;
  logic [ON_W-1:0] on_cnt_q, on_len_q;
  logic [ON_W:0]   sk_cnt_q, sk_len;
  logic [BW-1:0]   boost_left_q;
  logic            hf_edge;

  assign hf_edge = hf_rise_i | hf_fall_i;
  assign sk_len  = {1'b0, on_len_q} + {2'b00, on_len_q[ON_W-1:1]};
  assign req_o   = req_q;
  assign mode_o  = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= MODE_FIXED;
      req_q        <= 1'b0;
      armed_q      <= 1'b0;
      on_cnt_q     <= '0;
      on_len_q     <= ON_W'(1);
      sk_cnt_q     <= '0;
      boost_left_q <= '0;
    end else begin
      case (mode_q)
        MODE_FIXED: begin
          if (period_i) begin
            if (neg_done_i && !force_i) begin
              mode_q  <= MODE_SKIP;
              req_q   <= 1'b0;
              armed_q <= 1'b1;
            end else begin
              req_q    <= 1'b1;
              on_cnt_q <= '0;
            end
          end else begin
            if (req_q) begin
              if (pwm_off_i) begin
                req_q    <= 1'b0;
                on_len_q <= on_cnt_q + 1'b1;
              end else if (on_cnt_q != ON_SAT) begin
                on_cnt_q <= on_cnt_q + 1'b1;
              end
            end
            if (tre_i) begin
              mode_q       <= MODE_BOOST;
              boost_left_q <= BW'(HF_PER_SW);
            end
          end
        end
        MODE_BOOST: begin
          if (req_q && pwm_off_i) req_q <= 1'b0;
          if (hf_rise_i) begin
            if (boost_left_q == '0) begin
              mode_q <= MODE_FIXED;
            end else begin
              boost_left_q <= boost_left_q - 1'b1;
              req_q        <= 1'b1;
            end
          end
        end
        MODE_SKIP: begin
          if (req_q) begin
            if (sk_cnt_q == '0) begin
              req_q   <= 1'b0;
              armed_q <= 1'b0;
            end else begin
              sk_cnt_q <= sk_cnt_q - 1'b1;
            end
          end else if (period_i && (force_i || pos_done_i)) begin
            mode_q   <= MODE_FIXED;
            req_q    <= 1'b1;
            on_cnt_q <= '0;
          end else if (hf_edge) begin
            if (armed_q && fb_low_i) begin
              req_q    <= 1'b1;
              sk_cnt_q <= sk_len - 1'b1;
            end else begin
              armed_q <= 1'b1;
            end
          end
        end
        default: mode_q <= MODE_FIXED;
      endcase
    end
  end
endmodule

// File: rtl/bk_dead_time.sv
// Non-overlapping gate commands with separate dead times per direction.
module bk_dead_time #(
  parameter int DT_BT = 5,
  parameter int DT_TB = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic bot_en_i,
  output logic top_o,
  output logic bot_o
);
  localparam int GAP_MAX = (DT_BT > DT_TB) ? DT_BT : DT_TB;
  localparam int GW      = $clog2(GAP_MAX + 1);
  localparam logic [GW-1:0] GAP_SAT = GW'(GAP_MAX);
  localparam logic [GW-1:0] TOP_TH  = GW'(DT_BT - 1);
  localparam logic [GW-1:0] BOT_TH  = GW'(DT_TB - 1);

  logic          top_q, bot_q;
  logic [GW-1:0] gap_q;

  assign top_o = top_q;
  assign bot_o = bot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= 1'b0;
      bot_q <= 1'b0;
      gap_q <= '0;
    end else begin
      top_q <= req_i & ~bot_q & (top_q | (gap_q >= TOP_TH));
      bot_q <= ~req_i & bot_en_i & ~top_q & (bot_q | (gap_q >= BOT_TH));
      if (top_q || bot_q) gap_q <= '0;
      else if (gap_q != GAP_SAT) gap_q <= gap_q + 1'b1;
    end
  end
endmodule

// File: rtl/bk_gate_timing.sv
module bk_gate_timing
  import bk_gate_pkg::*;
#(
  parameter int RUN_LEN   = 8,
  parameter int ON_W      = 10,
  parameter int HF_PER_SW = 4,
  parameter int DT_BT     = 5,
  parameter int DT_TB     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_tick_i,
  input  logic       hf_rise_i,
  input  logic       hf_fall_i,
  input  logic       pwm_off_i,
  input  logic       fb_low_i,
  input  logic       zc_i,
  input  logic       tre_i,
  input  logic       fpwm_n_i,
  input  logic       ss_active_i,
  output logic       top_gate_o,
  output logic       bot_gate_o,
  output logic [1:0] mode_o
);
  logic     force_fixed, neg_done, pos_done, req, bot_en;
  bk_mode_e mode;

  assign force_fixed = ~fpwm_n_i | ss_active_i;
  assign bot_en      = ~((mode == MODE_SKIP) & zc_i);
  assign mode_o      = mode;

  bk_zc_runs #(.RUN_LEN(RUN_LEN)) runs_i (
    .clk(clk), .rst_n(rst_n), .period_i(sw_tick_i), .zc_i(zc_i),
    .neg_done_o(neg_done), .pos_done_o(pos_done)
  );

  bk_pulse_seq #(.ON_W(ON_W), .HF_PER_SW(HF_PER_SW)) seq_i (
    .clk(clk), .rst_n(rst_n), .period_i(sw_tick_i), .hf_rise_i(hf_rise_i),
    .hf_fall_i(hf_fall_i), .pwm_off_i(pwm_off_i), .fb_low_i(fb_low_i),
    .tre_i(tre_i), .force_i(force_fixed), .neg_done_i(neg_done),
    .pos_done_i(pos_done), .req_o(req), .mode_o(mode)
  );

  bk_dead_time #(.DT_BT(DT_BT), .DT_TB(DT_TB)) dt_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .bot_en_i(bot_en),
    .top_o(top_gate_o), .bot_o(bot_gate_o)
  );
endmodule

// File: rtl/bk_gate_timing_chk.sv
module bk_gate_timing_chk #(
  parameter int DT_BT = 5,
  parameter int DT_TB = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       zc_i,
  input logic       fpwm_n_i,
  input logic       ss_active_i,
  input logic       top_gate_o,
  input logic       bot_gate_o,
  input logic [1:0] mode_o
);
  logic [7:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run_q <= '0;
    else if (top_gate_o || bot_gate_o) low_run_q <= '0;
    else if (low_run_q != 8'hff) low_run_q <= low_run_q + 1'b1;
  end

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(top_gate_o && bot_gate_o)); // R3
  AST_TOP_DEAD_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(top_gate_o) |-> (int'(low_run_q) >= DT_BT)); // R3
  AST_BOT_DEAD_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bot_gate_o) |-> (int'(low_run_q) >= DT_TB)); // R3
  AST_SKIP_BOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && zc_i) |=> !bot_gate_o); // R10
  AST_FORCED_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    ((!fpwm_n_i || ss_active_i) && mode_o != 2'd1) |=> (mode_o != 2'd1)); // R5
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'd3); // R1
  AST_BOOST_FROM_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && $past(mode_o) != 2'd2) |-> ($past(mode_o) == 2'd0)); // R12
endmodule

bind bk_gate_timing bk_gate_timing_chk #(.DT_BT(DT_BT), .DT_TB(DT_TB)) chk_i (
  .clk(clk), .rst_n(rst_n), .zc_i(zc_i), .fpwm_n_i(fpwm_n_i),
  .ss_active_i(ss_active_i), .top_gate_o(top_gate_o),
  .bot_gate_o(bot_gate_o), .mode_o(mode_o)
);

// File: tb/bk_gate_timing_tb_top.sv
module bk_gate_timing_tb_top;
  localparam int DT_BT = 5;
  localparam int DT_TB = 4;
  localparam int PER   = 24;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic tick_s = 0, hf_r = 0, hf_f = 0, pwm = 0, fb = 0, zc = 0, tre = 0;
  logic fpwm_n = 1, ss = 0;
  logic tg, bg;
  logic [1:0] mode;

  bk_gate_timing dut_i (
    .clk(clk), .rst_n(rst_n), .sw_tick_i(tick_s), .hf_rise_i(hf_r),
    .hf_fall_i(hf_f), .pwm_off_i(pwm), .fb_low_i(fb), .zc_i(zc), .tre_i(tre),
    .fpwm_n_i(fpwm_n), .ss_active_i(ss), .top_gate_o(tg), .bot_gate_o(bg),
    .mode_o(mode)
  );

  int checks = 0, failures = 0;
  int exp_q[$];
  string tag_q[$];
  int hi_len = 0, low_run = 0;
  logic tg_prev = 0, bg_prev = 0;
  bit done = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_pulse(string req, int len);
    exp_q.push_back(len);
    tag_q.push_back(req);
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Monitor: measures every top pulse and pops the matching expectation.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (tg && bg) check("R3 both gates high", 1, 0);
      if (tg && !tg_prev) check("R3 top dead time met", int'(low_run >= DT_BT), 1);
      if (bg && !bg_prev) check("R3 bottom dead time met", int'(low_run >= DT_TB), 1);
      if (tg) hi_len++;
      else if (hi_len > 0) begin
        if (exp_q.size() == 0) check("R2 unexpected top pulse length", hi_len, 0);
        else begin
          automatic int e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(t, hi_len, e);
        end
        hi_len = 0;
      end
      low_run = (!tg && !bg) ? low_run + 1 : 0;
      tg_prev = tg;
      bg_prev = bg;
    end
  end

  task automatic period(int l, bit z, bit chk_bg);
    for (int i = 0; i < PER; i++) begin
      tick_s = (i == 0);
      pwm    = (i == l);
      zc     = z && (i >= l + 3) && (i <= 22);
      tick();
      if (chk_bg && i == 21) check("R4 bottom stays on with negative current", bg, 1);
    end
    tick_s = 0; pwm = 0; zc = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    tick(3);
    check("R1 top low in reset", tg, 0);
    check("R1 bottom low in reset", bg, 0);
    check("R1 mode fixed in reset", mode, 0);
    rst_n = 1;
    tick(DT_TB - 1);
    check("R1 bottom still off before dead time", bg, 0);
    tick();
    check("R1 bottom on after dead time", bg, 1);
    tick(4);

    // Forced PWM with persistent negative current
    fpwm_n = 0;
    for (int k = 0; k < 10; k++) begin
      expect_pulse("R2 fixed top pulse length", 10 - DT_BT);
      period(10, 1, k == 0);
    end
    check("R5 forced pin keeps fixed mode", mode, 0);

    // Soft-start with pin released
    fpwm_n = 1; ss = 1;
    for (int k = 0; k < 4; k++) begin
      expect_pulse("R2 fixed top pulse length", 10 - DT_BT);
      period(10, 1, 0);
    end
    check("R5 soft-start keeps fixed mode", mode, 0);
    expect_pulse("R2 fixed top pulse length", 10 - DT_BT);
    period(10, 0, 0);
    ss = 0;

    // Skip entry boundary
    for (int k = 0; k < 8; k++) begin
      expect_pulse("R2 fixed top pulse length", 10 - DT_BT);
      period(10, 1, 0);
    end
    check("R6 seven periods do not enter skip", mode, 0);
    tick_s = 1; zc = 1; tick(); tick_s = 0;
    tick(3);
    check("R6 eighth period enters skip", mode, 1);
    check("R10 bottom off on negative current in skip", bg, 0);

    // Skip firing
    fb = 1;
    tick(5);
    check("R8 no fire without a fast-clock edge", tg, 0);
    expect_pulse("R7 skip pulse is 1.5x on-time", 15);
    hf_r = 1; tick(); hf_r = 0;
    check("R8 top not yet on after strobe edge", tg, 0);
    tick();
    check("R8 top on two clocks after rising strobe", tg, 1);
    tick(3); pwm = 1; tick(); pwm = 0;
    tick(16);
    check("R7 skip pulse finished", tg, 0);
    hf_f = 1; tick(); hf_f = 0; tick();
    check("R9 first edge after pulse only re-arms", tg, 0);
    expect_pulse("R8 skip pulse on falling strobe", 15);
    tick(2);
    hf_f = 1; tick(); hf_f = 0; tick();
    check("R8 top on after falling strobe", tg, 1);
    tick(16);
    fb = 0;
    tre = 1; tick(); tre = 0; tick();
    check("R12 transient ignored in skip", mode, 1);

    // Skip exit boundary
    for (int k = 0; k < 8; k++) period(12, 0, 0);
    check("R11 seven clean periods stay in skip", mode, 1);
    expect_pulse("R11 fixed pulse at exit tick", 12 - DT_BT);
    period(12, 0, 0);
    check("R11 eighth clean period leaves skip", mode, 0);

    // Transient boost
    tre = 1; tick(); tre = 0;
    check("R12 transient enters boost", mode, 2);
    for (int k = 0; k < 4; k++) begin
      expect_pulse("R12 boost pulse length", 8 - DT_BT);
      hf_r = 1; tick(); hf_r = 0;
      tick(7); pwm = 1; tick(); pwm = 0;
      tick(8);
    end
    check("R12 still boost after four rises", mode, 2);
    hf_r = 1; tick(); hf_r = 0; tick();
    check("R12 fifth rise returns to fixed", mode, 0);
    expect_pulse("R2 fixed pulse after boost", 10 - DT_BT);
    period(10, 0, 0);

    tick(4);
    check("R2 all expected pulses observed", exp_q.size(), 0);
    finish_run();
  end
endmodule